// File: doc/BRIEF.md
# Multi-mode interval down-counter channel

This block is a single timer channel built around a wide down-counter. Software programs an interval length N; the channel loads N-1 and counts one step per clock until it reaches zero. That point is the end of the interval, and the interval therefore lasts exactly N cycles. What follows depends on the selected mode:

- **Repeat:** the counter reloads and keeps running.
- **One-shot:** the channel returns to idle.
- **One-shot stall:** the channel returns to idle, and a stall indicator is raised while it runs.

A sticky pending flag records each end of interval in the interrupting modes. The flag is gated by an interrupt-enable bit to form the channel interrupt.

The register-style interface has four parts:

- An interval write port carrying a force-load qualifier. Interval writes start, stop or retarget the channel.
- A read of the current count. It shows all ones while the channel is idle.
- A control write for the interrupt enable and the mode.
- A status write that clears the pending flag by writing one.

Address decoding and combining several channels are left to the surrounding logic.

Top module: `ivt_channel`

## Requirements
- R1: After a load the count read equals N-1 and falls by one each clock; the end of the interval is the cycle in which a running count is 0, so a repeating channel shows the same count every N cycles.
- R2: Writing a non-zero interval N while idle makes the channel run with count N-1 from the next cycle. Writing zero while idle leaves it idle.
- R3: Writing zero while running with the force qualifier set stops the channel at once. With the qualifier clear, the channel runs to the end of the current interval and then stops, setting the pending flag.
- R4: A non-zero interval written while running with the force qualifier set replaces the count with N-1 at once. With the qualifier clear, the count is not disturbed, and a repeating channel reloads the new N-1 at its next end of interval.
- R5: The interval read-back returns the held interval in its low bits, with the top bit (force qualifier position) always 0.
- R6: The mode field encoding is 0 repeat, 1 one-shot, 2 one-shot stall, and 3 behaves as repeat. One-shot modes go idle after their end of interval. Repeat modes reload in that same cycle.
- R7: Each end of interval in modes 0, 1 and 3 sets the pending flag, which stays set until a status write with clear bit 1. A clear bit of 0 has no effect. An end of interval in the same cycle as a clear leaves the flag set.
- R8: The interrupt output equals pending flag AND interrupt enable.
- R9: The running output is 1 while counting and 0 when stopped. The count read returns all ones while stopped.
- R10: In mode 2 the stall output is 1 exactly while the channel runs, and its end of interval does not set the pending flag.
- R11: After reset the channel is idle, the flag, enable, mode and interval are 0, and the count read is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ival_we | input | 1 | Interval write strobe |
| ival_wdata | input | CNT_W | Interval value N |
| ival_force | input | 1 | Force-load qualifier of the interval write |
| ival_rd | output | CNT_W+1 | Interval read-back, top bit always 0 |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_ie | input | 1 | Interrupt enable written by the control write |
| ctrl_mode | input | 2 | Mode written by the control write |
| stat_we | input | 1 | Status write strobe |
| stat_clr | input | 1 | Status write data for the flag: 1 clears, 0 no effect |
| cnt_rd | output | CNT_W | Current count, all ones while idle |
| pending | output | 1 | Sticky end-of-interval flag |
| running | output | 1 | Channel is counting |
| irq | output | 1 | Channel interrupt |
| stall | output | 1 | Running in one-shot stall mode |

## Verification
The hardest situation to reach from the ports is a register write landing in the exact cycle in which the count is zero. Two such cases matter: a flag clear racing a new end of interval, and an unforced interval write racing the reload. The stimulus reaches the first case by running a repeating interval of 1, so that every cycle is an end of interval and any clear collides with a set. It reaches the second by computing, from the load cycle, the cycle in which a known interval wraps, and then placing the unforced write before that wrap so the reload value can be observed. A sweep over intervals 1 to 6 in all four mode codes checks count, running, flag, stall and interrupt on every cycle against an arithmetic model.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [1:0] {
    MODE_REPEAT  = 2'd0,
    MODE_ONESHOT = 2'd1,
    MODE_STALL   = 2'd2,
    MODE_REP_ALT = 2'd3
  } ivt_mode_e;

  // Repeat behaviour for codes 0 and 3
  function automatic logic mode_reloads(ivt_mode_e m);
    return (m == MODE_REPEAT) || (m == MODE_REP_ALT);
  endfunction

  // Every mode except stall raises the pending flag
  function automatic logic mode_flags(ivt_mode_e m);
    return m != MODE_STALL;
  endfunction

endpackage

// File: rtl/ivt_cfg_regs.sv
module ivt_cfg_regs
  import ivt_pkg::*;
#(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ival_we,
  input  logic [CNT_W-1:0] ival_wdata,
  input  logic             ctrl_we,
  input  logic             ctrl_ie,
  input  logic [1:0]       ctrl_mode,
  output logic [CNT_W-1:0] ival_q,
  output logic             ie_q,
  output ivt_mode_e        mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival_q <= '0;
      ie_q   <= 1'b0;
      mode_q <= MODE_REPEAT;
    end else begin
      if (ival_we) ival_q <= ival_wdata;
      if (ctrl_we) begin
        ie_q   <= ctrl_ie;
        mode_q <= ivt_mode_e'(ctrl_mode);
      end
    end
  end

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ival_we,
  input  logic [CNT_W-1:0] ival_wdata,
  input  logic             ival_force,
  input  logic [CNT_W-1:0] ival_q,
  input  logic             reload_mode,
  output logic             run_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);

  function automatic logic [CNT_W-1:0] load_of(logic [CNT_W-1:0] n);
    return n - 1'b1;
  endfunction

  logic             wr_nonzero;
  logic [CNT_W-1:0] reload_src;
  logic             run_d;
  logic [CNT_W-1:0] cnt_d;

  assign wr_nonzero = (ival_wdata != '0);
  assign expire     = run_q && (cnt_q == '0);
  // An unforced write in the wrap cycle is the value taken by the reload
  assign reload_src = ival_we ? ival_wdata : ival_q;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (run_q) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else if (reload_mode && (reload_src != '0)) begin
        cnt_d = load_of(reload_src);
      end else begin
        run_d = 1'b0;
        cnt_d = '0;
      end
    end
    if (ival_we) begin
      if (!run_q || ival_force) begin
        if (wr_nonzero) begin
          run_d = 1'b1;
          cnt_d = load_of(ival_wdata);
        end else if (run_q) begin
          run_d = 1'b0;
          cnt_d = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  a_r2_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ival_we && !run_q && ival_wdata != '0) |=>
      (run_q && cnt_q == $past(ival_wdata) - 1'b1));

  a_r3_force_zero_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ival_we && ival_force && ival_wdata == '0) |=> !run_q);

  a_r1_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0 && !(ival_we && ival_force)) |=>
      (run_q && cnt_q == $past(cnt_q) - 1'b1));

  a_r6_oneshot_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reload_mode && !(ival_we && ival_force && ival_wdata != '0))
      |=> !run_q);

endmodule

// File: rtl/ivt_flag.sv
module ivt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic set_ok,
  input  logic stat_we,
  input  logic stat_clr,
  output logic flag_q
);

  logic set_ev;
  logic clr_ev;

  assign set_ev = expire && set_ok;
  assign clr_ev = stat_we && stat_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_ev) flag_q <= 1'b1;
    else if (clr_ev) flag_q <= 1'b0;
  end

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_ev) |=> flag_q);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag_q);

  a_r10_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !set_ok) |=> !flag_q);

endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ival_we,
  input  logic [CNT_W-1:0] ival_wdata,
  input  logic             ival_force,
  output logic [CNT_W:0]   ival_rd,
  input  logic             ctrl_we,
  input  logic             ctrl_ie,
  input  logic [1:0]       ctrl_mode,
  input  logic             stat_we,
  input  logic             stat_clr,
  output logic [CNT_W-1:0] cnt_rd,
  output logic             pending,
  output logic             running,
  output logic             irq,
  output logic             stall
);

  localparam logic [CNT_W-1:0] IDLE_READ = {CNT_W{1'b1}};

  logic [CNT_W-1:0] ival_q;
  logic             ie_q;
  ivt_mode_e        mode_q;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;
  logic             flag_q;

  ivt_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .ival_we(ival_we), .ival_wdata(ival_wdata),
    .ctrl_we(ctrl_we), .ctrl_ie(ctrl_ie), .ctrl_mode(ctrl_mode),
    .ival_q(ival_q), .ie_q(ie_q), .mode_q(mode_q)
  );

  ivt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .ival_we(ival_we), .ival_wdata(ival_wdata), .ival_force(ival_force),
    .ival_q(ival_q), .reload_mode(mode_reloads(mode_q)),
    .run_q(run_q), .cnt_q(cnt_q), .expire(expire)
  );

  ivt_flag u_flag (
    .clk(clk), .rst_n(rst_n),
    .expire(expire), .set_ok(mode_flags(mode_q)),
    .stat_we(stat_we), .stat_clr(stat_clr),
    .flag_q(flag_q)
  );

  assign ival_rd = {1'b0, ival_q};
  assign cnt_rd  = run_q ? cnt_q : IDLE_READ;
  assign pending = flag_q;
  assign running = run_q;
  assign irq     = flag_q && ie_q;
  assign stall   = run_q && (mode_q == MODE_STALL);

  a_r9_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (cnt_rd == IDLE_READ));

  a_r5_force_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ival_rd[CNT_W] == 1'b0);

  a_r10_stall_running: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> running);

endmodule

// File: tb/test_ivt_channel.sv
module test_ivt_channel;

  localparam int W = 31;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ival_we = 1'b0, ival_force = 1'b0;
  logic [W-1:0] ival_wdata = '0;
  logic [W:0] ival_rd;
  logic ctrl_we = 1'b0, ctrl_ie = 1'b0;
  logic [1:0] ctrl_mode = 2'd0;
  logic stat_we = 1'b0, stat_clr = 1'b0;
  logic [W-1:0] cnt_rd;
  logic pending, running, irq, stall;

  int n_total = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ivt_channel #(.CNT_W(W)) i_ivt_channel (
    .clk(clk), .rst_n(rst_n),
    .ival_we(ival_we), .ival_wdata(ival_wdata), .ival_force(ival_force),
    .ival_rd(ival_rd),
    .ctrl_we(ctrl_we), .ctrl_ie(ctrl_ie), .ctrl_mode(ctrl_mode),
    .stat_we(stat_we), .stat_clr(stat_clr),
    .cnt_rd(cnt_rd), .pending(pending), .running(running),
    .irq(irq), .stall(stall)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr_ival(input logic [W-1:0] v, input logic f);
    ival_we = 1'b1; ival_wdata = v; ival_force = f;
    step();
    ival_we = 1'b0; ival_force = 1'b0;
  endtask

  task automatic wr_ctrl(input logic ie, input logic [1:0] m);
    ctrl_we = 1'b1; ctrl_ie = ie; ctrl_mode = m;
    step();
    ctrl_we = 1'b0;
  endtask

  task automatic wr_stat(input logic c);
    stat_we = 1'b1; stat_clr = c;
    step();
    stat_we = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R11 reset state
    chk(running, 0, "R11 running");
    chk(pending, 0, "R11 pending");
    chk(cnt_rd, ONES, "R11 cnt_rd");
    chk(ival_rd, 0, "R11 ival_rd");
    chk(irq, 0, "R11 irq");
    chk(stall, 0, "R11 stall");

    // R2 zero while idle stays idle
    wr_ival(0, 1'b0);
    chk(running, 0, "R2 zero write idle");

    // Sweep: intervals 1..6, all mode codes (R1 R6 R7 R8 R9 R10)
    for (int n = 1; n <= 6; n++) begin
      for (int m = 0; m < 4; m++) begin
        wr_ival(0, 1'b1);
        wr_stat(1'b1);
        wr_ctrl(1'b1, 2'(m));
        wr_ival(W'(n), 1'b0);
        for (int k = 0; k <= 2 * n + 1; k++) begin
          bit rep, er, ef, es;
          logic [W-1:0] ec;
          if (k > 0) step();
          rep = (m == 0) || (m == 3);
          er  = rep || (k < n);
          ec  = !er ? ONES : (rep ? W'(n - 1 - (k % n)) : W'(n - 1 - k));
          ef  = (k >= n) && (m != 2);
          es  = er && (m == 2);
          chk(running, er, "R6 running");
          chk(cnt_rd, ec, "R1 cnt_rd");
          chk(pending, ef, "R7 pending");
          chk(stall, es, "R10 stall");
          chk(irq, ef, "R8 irq");
        end
      end
    end

    // R4 unforced write taken at wrap in repeat
    wr_ival(0, 1'b1);
    wr_stat(1'b1);
    wr_ctrl(1'b0, 2'd0);
    wr_ival(4, 1'b0);
    chk(cnt_rd, 3, "R2 start load");
    wr_ival(6, 1'b0);
    chk(cnt_rd, 2, "R4 unforced no disturb");
    chk(ival_rd, {1'b0, W'(6)}, "R5 readback");
    step(); step(); step();
    chk(cnt_rd, 5, "R4 reload new value");
    chk(pending, 1, "R7 set at wrap");
    chk(irq, 0, "R8 irq masked");

    // R4 forced replace
    wr_ival(9, 1'b1);
    chk(cnt_rd, 8, "R4 forced replace");
    chk(ival_rd[W], 0, "R5 force bit reads 0");

    // R7 write 0 no effect, write 1 clears
    wr_stat(1'b0);
    chk(pending, 1, "R7 clear-0 no effect");
    wr_stat(1'b1);
    chk(pending, 0, "R7 clear-1");

    // R3 zero unforced: stop at end
    wr_ival(3, 1'b1);
    chk(cnt_rd, 2, "R4 forced load 3");
    wr_ival(0, 1'b0);
    chk(running, 1, "R3 still running");
    chk(cnt_rd, 1, "R3 count continues");
    step();
    chk(cnt_rd, 0, "R3 at zero");
    step();
    chk(running, 0, "R3 stopped at end");
    chk(cnt_rd, ONES, "R9 idle read");
    chk(pending, 1, "R3 flag at end");

    // R3 zero forced: stop at once
    wr_stat(1'b1);
    wr_ival(5, 1'b0);
    step();
    wr_ival(0, 1'b1);
    chk(running, 0, "R3 forced stop");
    chk(pending, 0, "R3 no flag on forced stop");

    // R7 set wins over clear with interval 1 repeat
    wr_ival(1, 1'b0);
    step();
    chk(pending, 1, "R7 interval1 set");
    wr_stat(1'b1);
    chk(pending, 1, "R7 set beats clear");
    wr_ctrl(1'b1, 2'd0);
    chk(irq, 1, "R8 irq enabled");
    wr_ival(0, 1'b1);

    summary();
    $finish;
  end

endmodule